// File: doc/BRIEF.md
# Receive FIFO Flow-Control Pause Generator

This block watches how many bytes sit in a receive FIFO and decides when the link partner should be asked to stop sending and when it may resume. It turns the occupancy into 64-byte units and compares the result with two 9-bit levels packed into one threshold word. One level is the pause level and the other is the resume level. A two-state machine tracks whether the link is paused. It emits a one-cycle stop request on entry to the paused state and a one-cycle resume request on leaving it. Building and sending the pause frame itself is the job of a neighbouring block.

The block also drives a level that tells the receive DMA engine to start draining. This level is high while the FIFO holds at least a selectable byte count, chosen by a 3-bit code. All outputs are registered, so each one reflects the inputs sampled at the previous rising clock edge.

Top module: `pause_gen`

## Requirements
- R1: While reset (`rst`, synchronous, active high) is asserted and in the first cycle after it, all four outputs are 0 and the state is not-paused.
- R2: Occupancy is compared in 64-byte units: the comparison uses floor(occ_bytes_i / 64), so byte counts that differ only in their low 6 bits behave identically.
- R3: When not paused and units > pause level (thr_word_i bits 8:0), the next cycle shows xoff_req_o = 1 for exactly one cycle and paused_o = 1.
- R4: When paused, units < resume level (thr_word_i bits 20:12) and the R3 condition is false, the next cycle shows xon_req_o = 1 for one cycle and paused_o = 0.
- R5: No request is repeated while the state is held. A stop request appears only on the change from not-paused to paused, and a resume request only on the reverse change. The two requests are never high together.
- R6: If both the stop condition and the resume condition hold, the stop condition wins. A not-paused block pauses, and a paused block stays paused with no request.
- R7: dma_start_o is 1 in the cycle after occ_bytes_i >= 64 << start_code_i. Codes 6 and 7 use 2048 bytes.
- R8: Bits of thr_word_i outside 8:0 and 20:12 have no effect on any output.
- R9: Occupancy exactly equal to a level in units triggers neither the stop request (equal is not above) nor the resume request (equal is not below).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| occ_bytes_i | input | OCC_W (16) | Receive FIFO occupancy in bytes |
| thr_word_i | input | 32 | Packed levels: pause level in 8:0, resume level in 20:12 |
| start_code_i | input | 3 | DMA start threshold code, 64 << code bytes, 6 and 7 saturate to 2048 |
| xoff_req_o | output | 1 | One-cycle request to send a stop pause frame |
| xon_req_o | output | 1 | One-cycle request to send a resume pause frame |
| paused_o | output | 1 | Current flow-control state, 1 = paused |
| dma_start_o | output | 1 | Occupancy has reached the DMA start threshold |

## Verification
The hardest situation to reach is a paused block that sees both the stop and the resume condition at once. This needs an inverted level pair (resume level above pause level) together with occupancy above the pause level while already paused. Random threshold words rarely produce that sequence. A directed sequence therefore programs an inverted pair, pauses the block, and then holds occupancy between the levels. A second directed sequence places occupancy exactly on each level and one byte on either side of each 64-byte boundary. Random stimulus then mixes levels, codes and junk bits in the unused threshold fields.

// File: rtl/pause_gen_pkg.sv
package pause_gen_pkg;

    localparam int LVL_W      = 9;
    localparam int PAUSE_LSB  = 0;
    localparam int RESUME_LSB = 12;
    localparam int UNIT_SHIFT = 6;
    localparam int CODE_W     = 3;
    localparam int CODE_MAX   = 5;

    typedef struct packed {
        logic [LVL_W-1:0] pause_lvl;
        logic [LVL_W-1:0] resume_lvl;
    } lvl_pair_t;

    typedef struct packed {
        logic want_stop;
        logic want_resume;
    } flow_cond_t;

    typedef enum logic {
        FLOW_RUN  = 1'b0,
        FLOW_HOLD = 1'b1
    } flow_state_t;

    // Byte count selected by a start code; out-of-range codes saturate.
    function automatic logic [31:0] start_bytes(input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] c;
        c = (int'(code) > CODE_MAX) ? CODE_W'(CODE_MAX) : code;
        return 32'd64 << c;
    endfunction

endpackage

// File: rtl/pg_lvl_unpack.sv
module pg_lvl_unpack
    import pause_gen_pkg::*;
(
    input  logic [31:0] word_i,
    output lvl_pair_t   lvl_o
);
    always_comb begin
        lvl_o.pause_lvl  = word_i[PAUSE_LSB  +: LVL_W];
        lvl_o.resume_lvl = word_i[RESUME_LSB +: LVL_W];
    end
endmodule

// File: rtl/pg_level_cmp.sv
module pg_level_cmp
    import pause_gen_pkg::*;
#(
    parameter int OCC_W = 16
) (
    input  logic [OCC_W-1:0] occ_i,
    input  lvl_pair_t        lvl_i,
    output flow_cond_t       cond_o
);
    localparam int UNIT_W = OCC_W - UNIT_SHIFT;

    logic [UNIT_W-1:0] units;
    logic [31:0]       units_x;
    logic [31:0]       pause_x;
    logic [31:0]       resume_x;

    always_comb begin
        units    = occ_i[OCC_W-1:UNIT_SHIFT];
        units_x  = 32'(units);
        pause_x  = 32'(lvl_i.pause_lvl);
        resume_x = 32'(lvl_i.resume_lvl);
        cond_o.want_stop   = units_x > pause_x;
        cond_o.want_resume = units_x < resume_x;
    end
endmodule

// File: rtl/pg_flow_fsm.sv
module pg_flow_fsm
    import pause_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  flow_cond_t cond_i,
    output logic       stop_req_o,
    output logic       resume_req_o,
    output logic       paused_o
);
    flow_state_t state_q, state_d;
    logic        stop_d, resume_d;

    always_comb begin
        state_d  = state_q;
        stop_d   = 1'b0;
        resume_d = 1'b0;
        unique case (state_q)
            FLOW_RUN: begin
                if (cond_i.want_stop) begin
                    state_d = FLOW_HOLD;
                    stop_d  = 1'b1;
                end
            end
            FLOW_HOLD: begin
                // Stop condition outranks resume: stay paused.
                if (cond_i.want_resume && !cond_i.want_stop) begin
                    state_d  = FLOW_RUN;
                    resume_d = 1'b1;
                end
            end
            default: state_d = FLOW_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= FLOW_RUN;
            stop_req_o   <= 1'b0;
            resume_req_o <= 1'b0;
        end else begin
            state_q      <= state_d;
            stop_req_o   <= stop_d;
            resume_req_o <= resume_d;
        end
    end

    assign paused_o = (state_q == FLOW_HOLD);

    p_req_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(stop_req_o && resume_req_o));
    p_stop_enters_hold_r3: assert property (@(posedge clk) disable iff (rst)
        stop_req_o |-> (paused_o && !$past(paused_o)));
    p_resume_leaves_hold_r4: assert property (@(posedge clk) disable iff (rst)
        resume_req_o |-> (!paused_o && $past(paused_o)));
    p_stop_single_r5: assert property (@(posedge clk) disable iff (rst)
        stop_req_o |=> !stop_req_o);
    p_resume_single_r5: assert property (@(posedge clk) disable iff (rst)
        resume_req_o |=> !resume_req_o);
    p_stop_priority_r6: assert property (@(posedge clk) disable iff (rst)
        (paused_o && cond_i.want_stop) |=> (paused_o && !resume_req_o));
endmodule

// File: rtl/pg_start_det.sv
module pg_start_det
    import pause_gen_pkg::*;
#(
    parameter int OCC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OCC_W-1:0]  occ_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              start_o
);
    logic [31:0] limit;
    logic        reach;

    always_comb begin
        limit = start_bytes(code_i);
        reach = 32'(occ_i) >= limit;
    end

    always_ff @(posedge clk) begin
        if (rst) start_o <= 1'b0;
        else     start_o <= reach;
    end

    p_start_floor_r7: assert property (@(posedge clk) disable iff (rst)
        start_o |-> ($past(32'(occ_i)) >= 32'd64));
    p_start_ceiling_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(32'(occ_i)) >= 32'd2048) && !$past(rst) |-> start_o);
endmodule

// File: rtl/pause_gen.sv
module pause_gen
    import pause_gen_pkg::*;
#(
    parameter int OCC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] occ_bytes_i,
    input  logic [31:0]      thr_word_i,
    input  logic [2:0]       start_code_i,
    output logic             xoff_req_o,
    output logic             xon_req_o,
    output logic             paused_o,
    output logic             dma_start_o
);
    lvl_pair_t  lvl;
    flow_cond_t cond;

    pg_lvl_unpack u_unpack (
        .word_i (thr_word_i),
        .lvl_o  (lvl)
    );

    pg_level_cmp #(.OCC_W(OCC_W)) u_cmp (
        .occ_i  (occ_bytes_i),
        .lvl_i  (lvl),
        .cond_o (cond)
    );

    pg_flow_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cond_i       (cond),
        .stop_req_o   (xoff_req_o),
        .resume_req_o (xon_req_o),
        .paused_o     (paused_o)
    );

    pg_start_det #(.OCC_W(OCC_W)) u_start (
        .clk     (clk),
        .rst     (rst),
        .occ_i   (occ_bytes_i),
        .code_i  (start_code_i),
        .start_o (dma_start_o)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!xoff_req_o && !xon_req_o && !paused_o && !dma_start_o));
endmodule

// File: tb/pause_gen_tb_top.sv
module pause_gen_tb_top;
    localparam int OCC_W = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic [OCC_W-1:0] occ;
    logic [31:0]      thr;
    logic [2:0]       code;
    logic             xoff, xon, paused, dstart;

    int n_checks = 0;
    int n_fail   = 0;
    bit m_paused = 1'b0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    pause_gen #(.OCC_W(OCC_W)) dut_i (
        .clk(clk), .rst(rst), .occ_bytes_i(occ), .thr_word_i(thr),
        .start_code_i(code), .xoff_req_o(xoff), .xon_req_o(xon),
        .paused_o(paused), .dma_start_o(dstart)
    );

    function automatic int lim_bytes(input int c);
        if (c >= 6) return 2048;
        return 64 * (2 ** c);
    endfunction

    function automatic int pack_thr(input int p, input int r, input int junk);
        return (junk & 32'hFFE0_0E00) | ((r & 511) << 12) | (p & 511);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b occ=%0d thr=%h code=%0d",
                     req, act, exp, occ, thr, code);
        end
    endtask

    // Drive one cycle at a falling edge, check at the next falling edge.
    task automatic cyc(input int o, input int p, input int r, input int junk,
                       input int c, input string req);
        int  u;
        bit  stop_c, res_c, e_xoff, e_xon;
        occ  = o[OCC_W-1:0];
        thr  = pack_thr(p, r, junk);
        code = c[2:0];
        u = o / 64;
        stop_c = u > (p & 511);
        res_c  = u < (r & 511);
        e_xoff = 1'b0;
        e_xon  = 1'b0;
        if (!m_paused && stop_c) begin
            e_xoff = 1'b1; m_paused = 1'b1;
        end else if (m_paused && res_c && !stop_c) begin
            e_xon = 1'b1; m_paused = 1'b0;
        end
        @(negedge clk);
        chk({req, " xoff"},   xoff,   e_xoff);
        chk({req, " xon"},    xon,    e_xon);
        chk({req, " paused"}, paused, m_paused);
        chk({req, " dstart"}, dstart, (o >= lim_bytes(c)));
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        rst = 1'b1; occ = '0; thr = '0; code = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 xoff", xoff, 1'b0);
        chk("R1 xon", xon, 1'b0);
        chk("R1 paused", paused, 1'b0);
        chk("R1 dstart", dstart, 1'b0);
        occ = 16'd4000; thr = 32'h0;
        @(negedge clk);
        chk("R1 held in reset", paused, 1'b0);
        rst = 1'b0;
        occ = '0;
        @(negedge clk);
        chk("R1 after reset", xoff, 1'b0);

        // R9/R2: boundaries with pause level 10, resume level 4
        cyc(10*64+63, 10, 4, 0, 0, "R9 equal pause no xoff");
        cyc(11*64-1,  10, 4, 0, 0, "R2 below unit edge");
        cyc(11*64,    10, 4, 0, 0, "R3 xoff above");
        cyc(12*64,    10, 4, 0, 0, "R5 no repeat xoff");
        cyc(4*64,     10, 4, 0, 0, "R9 equal resume no xon");
        cyc(4*64-1,   10, 4, 0, 0, "R4 xon below");
        cyc(0,        10, 4, 0, 0, "R5 no repeat xon");

        // R6: inverted levels (resume 20 > pause 5)
        cyc(8*64,  5, 20, 0, 1, "R6 both from run -> xoff");
        cyc(8*64,  5, 20, 0, 1, "R6 both while paused stay");
        cyc(3*64,  5, 20, 0, 1, "R4 inverted resume");

        // R8: junk bits in unused fields
        cyc(3*64,  5, 20, 32'hFFFF_FFFF, 2, "R8 junk no effect");
        cyc(6*64,  5, 20, 32'hA5A5_A5A5, 2, "R8 junk xoff");
        cyc(2*64,  5, 20, 32'h5A5A_5A5A, 2, "R8 junk xon");

        // R7: start threshold edges for every code
        for (int c = 0; c < 8; c++) begin
            cyc(lim_bytes(c) - 1, 511, 0, 0, c, "R7 below start");
            cyc(lim_bytes(c),     511, 0, 0, c, "R7 at start");
        end

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int o, p, r;
            o = (i % 3 == 0) ? int'($urandom_range(0, 65535)) : int'($urandom_range(0, 4095));
            p = int'($urandom_range(0, 63));
            r = int'($urandom_range(0, 63));
            cyc(o, p, r, int'($urandom), int'($urandom_range(0, 7)), "R3/R4/R7 random");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule